// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the hazard-tracking core of a single-issue machine that has several unpipelined execution units. Decoded instructions arrive one at a time in program order. Each one names an operation, a destination register, two source registers and the unit that must execute it. The controller moves every instruction through four phases:

1. Issue.
2. Operand read.
3. Execution.
4. Result write.

It keeps a status record for each unit and a producer table for each register. From these it decides when an instruction may enter a unit, when a unit may read its operands, and when a unit may commit its result.

Hazards are resolved only by stalling, with no forwarding and no renaming:

- **Structural and output conflicts** hold the whole instruction stream at issue.
- **Missing operands** hold an instruction inside its unit.
- **Anti-dependences** hold a finished result inside its unit until every older reader of that register has read it.

Values pass between instructions only through the register file. The register file is modelled as a small array, and each unit's execution time is a parameterised countdown. A read port lets the environment inspect the register file, and a write-event port shows each result as it commits.

Top module: `sb_issue_ctrl`

## Requirements
- R1: Issue is strictly in program order. `in_ready` is low while the unit named by `in_unit` still holds an instruction, and no later instruction can pass the stalled one.
- R2: `in_ready` is low while any instruction in flight will write the register named by `in_dst`, so each register has at most one pending writer.
- R3: An instruction reads its operands only once neither source has a pending writer. The values it uses are those committed by the older producers.
- R4: A unit with index u has latency LAT(u) = BASE_LAT + u*LAT_STEP. An instruction accepted at a clock edge whose operands are ready and which meets no conflict shows `wb_valid` in the cycle that starts LAT(u)+1 edges later.
- R5: A finished unit holds its result, with `wb_valid` low for it, while another unit has not yet read a source equal to its destination. It commits in the cycle after that read.
- R6: At most one operand read and at most one result write are granted per cycle. Among the contenders, the lowest unit index wins.
- R7: A result write frees the unit and the register's pending entry from the next cycle on. Units waiting on that result become ready to read.
- R8: Every committed result carries the register and the value of the same instruction under plain sequential execution. After draining, the register file equals that sequential outcome.
- R9: After reset, `in_ready` is high, `wb_valid` is low, and register i holds the value i.
- R10: The operation code maps 0 to add, 1 to subtract, 2 to XOR and 3 to OR. Results wrap modulo 2^DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented |
| in_op | input | 2 | Operation code |
| in_dst | input | $clog2(NUM_REGS) | Destination register |
| in_src_a | input | $clog2(NUM_REGS) | First source register |
| in_src_b | input | $clog2(NUM_REGS) | Second source register |
| in_unit | input | $clog2(NUM_UNITS) | Target execution unit |
| in_ready | output | 1 | Instruction accepted at the next edge if valid |
| wb_valid | output | 1 | A result commits at the next edge |
| wb_unit | output | $clog2(NUM_UNITS) | Unit committing |
| wb_reg | output | $clog2(NUM_REGS) | Register being written |
| wb_data | output | DATA_W | Value being written |
| peek_addr | input | $clog2(NUM_REGS) | Register file inspection address |
| peek_data | output | DATA_W | Register file contents at peek_addr |

## Verification
For an unhindered instruction accepted at edge E, `wb_valid` appears in the cycle after edge E+LAT(u)+1. For two consumers released by the same producer write in cycle W, the lower-indexed one reads at edge W+2 and commits in cycle W+2+LAT, while the other reads one edge later. A result held for an anti-dependence commits exactly two cycles after the write that releases its reader. The bench samples every port at the falling edge, after the registers have settled. It records the cycle number of each acceptance and each commit, and it compares those numbers with the counts above. Values are checked at each commit against a sequential model of the accepted stream.

// File: rtl/sb_pkg.sv
package sb_pkg;
   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_XOR = 2'd2,
      ALU_OR  = 2'd3
   } alu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_EXEC = 2'd2,
      ST_DONE = 2'd3
   } unit_state_e;
endpackage

// File: rtl/sb_prio_arb.sv
module sb_prio_arb #(
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   output logic [N-1:0]         gnt,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IDX_W = $clog2(N);

   // lowest index wins: scan downward so the last hit is the smallest
   always_comb begin
      gnt = '0;
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
            any    = 1'b1;
            idx    = IDX_W'(i);
         end
      end
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R6
   AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0); // R6
endmodule

// File: rtl/sb_regfile.sv
module sb_regfile #(
   parameter int NUM_REGS  = 8,
   parameter int DATA_W    = 16,
   parameter int NUM_UNITS = 4
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic [$clog2(NUM_REGS)-1:0]                ra1,
   input  logic [$clog2(NUM_REGS)-1:0]                ra2,
   input  logic [$clog2(NUM_REGS)-1:0]                ra3,
   output logic [DATA_W-1:0]                          rd1,
   output logic [DATA_W-1:0]                          rd2,
   output logic [DATA_W-1:0]                          rd3,
   input  logic                                       we_en,
   input  logic [$clog2(NUM_REGS)-1:0]                we_addr,
   input  logic [DATA_W-1:0]                          we_data,
   input  logic                                       iss_en,
   input  logic [$clog2(NUM_REGS)-1:0]                iss_dst,
   input  logic [$clog2(NUM_UNITS)-1:0]               iss_unit,
   output logic [NUM_REGS-1:0]                        pend_v,
   output logic [NUM_REGS-1:0][$clog2(NUM_UNITS)-1:0] pend_id
);
   logic [NUM_REGS-1:0][DATA_W-1:0] mem;

   assign rd1 = mem[ra1];
   assign rd2 = mem[ra2];
   assign rd3 = mem[ra3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            mem[i]     <= DATA_W'(i);
            pend_v[i]  <= 1'b0;
            pend_id[i] <= '0;
         end
      end else begin
         if (we_en) begin
            mem[we_addr]    <= we_data;
            pend_v[we_addr] <= 1'b0;
         end
         if (iss_en) begin
            pend_v[iss_dst]  <= 1'b1;
            pend_id[iss_dst] <= iss_unit;
         end
      end
   end

   AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      we_en |=> !pend_v[$past(we_addr)]); // R7
endmodule

// File: rtl/sb_unit.sv
module sb_unit
   import sb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int RA_W   = 3,
   parameter int UID_W  = 2,
   parameter int LAT    = 2,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_en,
   input  alu_op_e           iss_op,
   input  logic [RA_W-1:0]   iss_fi,
   input  logic [RA_W-1:0]   iss_fj,
   input  logic [RA_W-1:0]   iss_fk,
   input  logic [UID_W-1:0]  iss_qj,
   input  logic [UID_W-1:0]  iss_qk,
   input  logic              iss_rj,
   input  logic              iss_rk,
   input  logic              rd_gnt,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic              wb_en,
   input  logic [UID_W-1:0]  wb_id,
   input  logic              wb_gnt,
   output logic              busy,
   output logic              rd_req,
   output logic              done,
   output logic [RA_W-1:0]   fi,
   output logic [RA_W-1:0]   fj,
   output logic [RA_W-1:0]   fk,
   output logic              rj,
   output logic              rk,
   output logic [DATA_W-1:0] result
);
   unit_state_e       st;
   alu_op_e           op_q;
   logic [UID_W-1:0]  qj_q, qk_q;
   logic [DATA_W-1:0] a_q, b_q, res_q, alu;
   logic [CNT_W-1:0]  cnt_q;

   always_comb begin
      case (op_q)
         ALU_ADD: alu = a_q + b_q;
         ALU_SUB: alu = a_q - b_q;
         ALU_XOR: alu = a_q ^ b_q;
         default: alu = a_q | b_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         op_q  <= ALU_ADD;
         fi    <= '0;
         fj    <= '0;
         fk    <= '0;
         qj_q  <= '0;
         qk_q  <= '0;
         rj    <= 1'b0;
         rk    <= 1'b0;
         a_q   <= '0;
         b_q   <= '0;
         res_q <= '0;
         cnt_q <= '0;
      end else begin
         case (st)
            ST_IDLE: if (iss_en) begin
               st   <= ST_WAIT;
               op_q <= iss_op;
               fi   <= iss_fi;
               fj   <= iss_fj;
               fk   <= iss_fk;
               qj_q <= iss_qj;
               qk_q <= iss_qk;
               rj   <= iss_rj;
               rk   <= iss_rk;
            end
            ST_WAIT: begin
               if (rd_gnt) begin
                  rj    <= 1'b0;
                  rk    <= 1'b0;
                  a_q   <= opa;
                  b_q   <= opb;
                  cnt_q <= CNT_W'(LAT - 1);
                  st    <= ST_EXEC;
               end else begin
                  if (wb_en && !rj && qj_q == wb_id) rj <= 1'b1;
                  if (wb_en && !rk && qk_q == wb_id) rk <= 1'b1;
               end
            end
            ST_EXEC: begin
               if (cnt_q == '0) begin
                  st    <= ST_DONE;
                  res_q <= alu;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: if (wb_gnt) st <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (st != ST_IDLE);
   assign rd_req = (st == ST_WAIT) && rj && rk;
   assign done   = (st == ST_DONE);
   assign result = res_q;

   AST_ISSUE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      iss_en |-> st == ST_IDLE); // R1
   AST_READ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_gnt |-> (st == ST_WAIT && rj && rk)); // R3
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE && !wb_gnt) |=> (st == ST_DONE && $stable(res_q))); // R5
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
   import sb_pkg::*;
#(
   parameter int NUM_UNITS = 4,
   parameter int NUM_REGS  = 8,
   parameter int DATA_W    = 16,
   parameter int BASE_LAT  = 2,
   parameter int LAT_STEP  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [1:0]                   in_op,
   input  logic [$clog2(NUM_REGS)-1:0]  in_dst,
   input  logic [$clog2(NUM_REGS)-1:0]  in_src_a,
   input  logic [$clog2(NUM_REGS)-1:0]  in_src_b,
   input  logic [$clog2(NUM_UNITS)-1:0] in_unit,
   output logic                         in_ready,
   output logic                         wb_valid,
   output logic [$clog2(NUM_UNITS)-1:0] wb_unit,
   output logic [$clog2(NUM_REGS)-1:0]  wb_reg,
   output logic [DATA_W-1:0]            wb_data,
   input  logic [$clog2(NUM_REGS)-1:0]  peek_addr,
   output logic [DATA_W-1:0]            peek_data
);
   localparam int UID_W   = $clog2(NUM_UNITS);
   localparam int RA_W    = $clog2(NUM_REGS);
   localparam int MAX_LAT = BASE_LAT + (NUM_UNITS - 1) * LAT_STEP;
   localparam int CNT_W   = $clog2(MAX_LAT + 1);

   if (NUM_UNITS < 2 || (1 << UID_W) != NUM_UNITS) begin : g_bad_units
      $error("NUM_UNITS must be a power of two of at least 2");
   end
   if (NUM_REGS < 2 || (1 << RA_W) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if (BASE_LAT < 1 || LAT_STEP < 0) begin : g_bad_lat
      $error("latency parameters out of range");
   end

   logic [NUM_UNITS-1:0]             u_busy, u_rdreq, u_done, u_rj, u_rk;
   logic [NUM_UNITS-1:0]             war_blk, wb_req, rd_gnt, wb_gnt;
   logic [NUM_UNITS-1:0][RA_W-1:0]   u_fi, u_fj, u_fk;
   logic [NUM_UNITS-1:0][DATA_W-1:0] u_res;
   logic [NUM_REGS-1:0]              pend_v;
   logic [NUM_REGS-1:0][UID_W-1:0]   pend_id;
   logic                             rd_any, wb_any, issue_fire;
   logic [UID_W-1:0]                 rd_idx, wb_idx;
   logic [DATA_W-1:0]                opa, opb;
   logic                             src_a_wait, src_b_wait;

   assign in_ready   = !u_busy[in_unit] && !pend_v[in_dst];
   assign issue_fire = in_valid && in_ready;

   // a producer committing this very cycle counts as already written
   assign src_a_wait = pend_v[in_src_a] && !(wb_any && pend_id[in_src_a] == wb_idx);
   assign src_b_wait = pend_v[in_src_b] && !(wb_any && pend_id[in_src_b] == wb_idx);

   // anti-dependence: hold a finished unit while someone still has to read its target
   always_comb begin
      war_blk = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         for (int v = 0; v < NUM_UNITS; v++) begin
            if (v != u && ((u_rj[v] && u_fj[v] == u_fi[u]) ||
                           (u_rk[v] && u_fk[v] == u_fi[u])))
               war_blk[u] = 1'b1;
         end
      end
   end
   assign wb_req = u_done & ~war_blk;

   sb_prio_arb #(.N(NUM_UNITS)) u_rd_arb (
      .clk(clk), .rst_n(rst_n), .req(u_rdreq), .gnt(rd_gnt), .any(rd_any), .idx(rd_idx));

   sb_prio_arb #(.N(NUM_UNITS)) u_wb_arb (
      .clk(clk), .rst_n(rst_n), .req(wb_req), .gnt(wb_gnt), .any(wb_any), .idx(wb_idx));

   sb_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_UNITS(NUM_UNITS)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra1(u_fj[rd_idx]), .ra2(u_fk[rd_idx]), .ra3(peek_addr),
      .rd1(opa), .rd2(opb), .rd3(peek_data),
      .we_en(wb_any), .we_addr(u_fi[wb_idx]), .we_data(u_res[wb_idx]),
      .iss_en(issue_fire), .iss_dst(in_dst), .iss_unit(in_unit),
      .pend_v(pend_v), .pend_id(pend_id));

   for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
      sb_unit #(
         .DATA_W(DATA_W), .RA_W(RA_W), .UID_W(UID_W),
         .LAT(BASE_LAT + g * LAT_STEP), .CNT_W(CNT_W)
      ) u_fu (
         .clk(clk), .rst_n(rst_n),
         .iss_en(issue_fire && in_unit == UID_W'(g)),
         .iss_op(alu_op_e'(in_op)),
         .iss_fi(in_dst), .iss_fj(in_src_a), .iss_fk(in_src_b),
         .iss_qj(pend_id[in_src_a]), .iss_qk(pend_id[in_src_b]),
         .iss_rj(!src_a_wait), .iss_rk(!src_b_wait),
         .rd_gnt(rd_gnt[g]), .opa(opa), .opb(opb),
         .wb_en(wb_any), .wb_id(wb_idx), .wb_gnt(wb_gnt[g]),
         .busy(u_busy[g]), .rd_req(u_rdreq[g]), .done(u_done[g]),
         .fi(u_fi[g]), .fj(u_fj[g]), .fk(u_fk[g]),
         .rj(u_rj[g]), .rk(u_rk[g]), .result(u_res[g]));
   end

   assign wb_valid = wb_any;
   assign wb_unit  = wb_idx;
   assign wb_reg   = u_fi[wb_idx];
   assign wb_data  = u_res[wb_idx];
endmodule

// File: tb/tb_sb_issue_ctrl.sv
module tb_sb_issue_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = '0;
   logic [2:0]  in_dst = '0, in_src_a = '0, in_src_b = '0, peek_addr = '0;
   logic [1:0]  in_unit = '0;
   logic        in_ready, wb_valid;
   logic [1:0]  wb_unit;
   logic [2:0]  wb_reg;
   logic [15:0] wb_data, peek_data;

   int          cyc = 0;
   int          checks = 0;
   int          fails = 0;
   int          last_issue_cyc = 0;
   int          last_wb_cyc [4];
   logic [15:0] model [8];
   logic [2:0]  exp_dst [4];
   logic [15:0] exp_val [4];
   bit          exp_vld [4];

   sb_issue_ctrl dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_unit(in_unit),
      .in_ready(in_ready), .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_reg(wb_reg),
      .wb_data(wb_data), .peek_addr(peek_addr), .peek_data(peek_data));

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] calc(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
      case (op)
         2'd0:    return a + b;
         2'd1:    return a - b;
         2'd2:    return a ^ b;
         default: return a | b;
      endcase
   endfunction

   function automatic int lat_of(input int u);
      return 2 + 2 * u;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // sequential reference and commit checking
   always @(negedge clk) begin
      if (rst_n) begin
         if (wb_valid) begin
            check(exp_vld[wb_unit], "R8", "commit from unit holding an instruction", 0, 1);
            check(wb_reg == exp_dst[wb_unit], "R8", "commit register", wb_reg, exp_dst[wb_unit]);
            check(wb_data == exp_val[wb_unit], "R3", "commit value", wb_data, exp_val[wb_unit]);
            exp_vld[wb_unit] = 1'b0;
            last_wb_cyc[wb_unit] = cyc;
         end
         if (in_valid && in_ready) begin
            exp_val[in_unit] = calc(in_op, model[in_src_a], model[in_src_b]);
            exp_dst[in_unit] = in_dst;
            exp_vld[in_unit] = 1'b1;
            model[in_dst]    = exp_val[in_unit];
            last_issue_cyc   = cyc + 1;
         end
      end
   end

   task automatic issue(input logic [1:0] op, input logic [2:0] d, input logic [2:0] a,
                        input logic [2:0] b, input logic [1:0] u);
      in_op = op; in_dst = d; in_src_a = a; in_src_b = b; in_unit = u; in_valid = 1'b1;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_vld[0] || exp_vld[1] || exp_vld[2] || exp_vld[3]) @(posedge clk);
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      finish_run();
   end

   initial begin
      int t0, w3;
      for (int i = 0; i < 8; i++) model[i] = 16'(i);
      for (int i = 0; i < 4; i++) begin exp_vld[i] = 1'b0; last_wb_cyc[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9 reset state
      @(negedge clk);
      check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
      check(wb_valid == 1'b0, "R9", "wb_valid after reset", wb_valid, 0);
      for (int i = 0; i < 8; i++) begin
         peek_addr = 3'(i); #1;
         check(peek_data == 16'(i), "R9", "register reset value", peek_data, i);
      end
      @(posedge clk); #1;

      // R4 unhindered latency, unit 2
      issue(2'd0, 3'd1, 3'd2, 3'd3, 2'd2);
      t0 = last_issue_cyc;
      drain();
      check(last_wb_cyc[2] == t0 + lat_of(2) + 1, "R4", "commit cycle unit 2",
            last_wb_cyc[2], t0 + lat_of(2) + 1);
      issue(2'd1, 3'd4, 3'd1, 3'd6, 2'd0);
      t0 = last_issue_cyc;
      drain();
      check(last_wb_cyc[0] == t0 + lat_of(0) + 1, "R4", "commit cycle unit 0",
            last_wb_cyc[0], t0 + lat_of(0) + 1);
      peek_addr = 3'd1; #1;
      check(peek_data == 16'd5, "R10", "add result", peek_data, 5);
      peek_addr = 3'd4; #1;
      check(peek_data == 16'hFFFF, "R10", "subtract wraps", peek_data, 16'hFFFF);

      // R1 structural stall, R7 release on commit
      issue(2'd0, 3'd5, 3'd0, 3'd0, 2'd3);
      in_op = 2'd3; in_dst = 3'd6; in_src_a = 3'd0; in_src_b = 3'd1; in_unit = 2'd3; in_valid = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b0, "R1", "ready while unit busy", in_ready, 0);
      while (!(wb_valid && wb_unit == 2'd3)) @(negedge clk);
      check(in_ready == 1'b0, "R7", "ready during commit cycle", in_ready, 0);
      @(negedge clk);
      check(in_ready == 1'b1, "R7", "ready after commit", in_ready, 1);
      @(posedge clk); #1;
      in_valid = 1'b0;
      drain();

      // R2 output conflict
      issue(2'd2, 3'd2, 3'd0, 3'd1, 2'd3);
      in_unit = 2'd0; in_dst = 3'd2;
      @(negedge clk);
      check(in_ready == 1'b0, "R2", "ready with pending writer", in_ready, 0);
      in_dst = 3'd3; #1;
      check(in_ready == 1'b1, "R2", "ready with free destination", in_ready, 1);
      @(posedge clk); #1;
      issue(2'd0, 3'd2, 3'd4, 3'd5, 2'd0);
      drain();
      check(last_wb_cyc[0] > last_wb_cyc[3], "R2", "second writer commits later",
            last_wb_cyc[0], last_wb_cyc[3] + 1);

      // R5 anti-dependence hold
      issue(2'd0, 3'd0, 3'd1, 3'd1, 2'd3);
      issue(2'd0, 3'd6, 3'd0, 3'd2, 2'd1);
      issue(2'd2, 3'd2, 3'd3, 3'd4, 2'd0);
      drain();
      check(last_wb_cyc[0] == last_wb_cyc[3] + 2, "R5", "held result commit cycle",
            last_wb_cyc[0], last_wb_cyc[3] + 2);

      // R6 read priority among units released together
      issue(2'd0, 3'd7, 3'd0, 3'd1, 2'd3);
      issue(2'd0, 3'd3, 3'd7, 3'd1, 2'd0);
      issue(2'd3, 3'd4, 3'd7, 3'd2, 2'd1);
      drain();
      w3 = last_wb_cyc[3];
      check(last_wb_cyc[0] == w3 + 2 + lat_of(0), "R6", "low index reads first",
            last_wb_cyc[0], w3 + 2 + lat_of(0));
      check(last_wb_cyc[1] == w3 + 3 + lat_of(1), "R6", "high index reads next",
            last_wb_cyc[1], w3 + 3 + lat_of(1));

      // random stream
      void'($urandom(32'd24681));
      for (int n = 0; n < 300; n++) begin
         issue(2'($urandom_range(3, 0)), 3'($urandom_range(7, 0)), 3'($urandom_range(7, 0)),
               3'($urandom_range(7, 0)), 2'($urandom_range(3, 0)));
      end
      drain();

      // R8 final contents, R7 nothing left pending
      @(negedge clk);
      check(in_ready == 1'b1, "R7", "ready after drain", in_ready, 1);
      for (int i = 0; i < 8; i++) begin
         peek_addr = 3'(i); #1;
         check(peek_data == model[i], "R8", "final register", peek_data, model[i]);
      end
      finish_run();
   end
endmodule